// File: doc/BRIEF.md
# Idle-Triggered Output Freeze and Sleep Controller

This block sits beside a small logic core and decides when that core may drop into a low-power state. On every sample clock it compares the monitored vector with the value it had one cycle earlier. The monitored vector holds the core's dedicated inputs, its bidirectional pin inputs, the clock-select line and the core's internal feedback lines. Any differing bit counts as activity. A counter measures how long the vector has stayed unchanged. When that count reaches a programmable threshold, the controller raises a sleep flag and freezes the registered copy of the core outputs. The pins then keep their last values while the core is powered down.

The first transition seen during sleep wakes the block. The output register stays frozen for one further cycle after the sleep flag drops, which gives the waking logic time to settle before the next core result is passed through. This extra cycle is the wake penalty.

A separate supply-valid input gates the output enables. Until that input has been seen high, every output enable stays low, so the pins float during power-up.

Top module: `idle_pwrdn_ctrl`

## Requirements
- R1: Activity is any bit of `monIn` differing from its value in the previous cycle. Any such difference in a cycle forces `sleep` low in the next cycle. The value of `monIn` present during reset counts as the previous value for the first cycle after reset.
- R2: The idle count starts at 0 after reset and returns to 0 on activity. In each cycle without activity it advances by one until it reaches `IDLE_CYCLES`, where it stays. `sleep` is high exactly while the count equals `IDLE_CYCLES`. Without activity, `sleep` therefore rises after `IDLE_CYCLES` clock edges following reset or the last activity.
- R3: While awake, `pinOut` shows the `coreOut` value of the previous cycle, one register stage.
- R4: In every cycle in which `sleep` is high, the output register holds. `pinOut` keeps the value captured in the last cycle before `sleep` rose, whatever `coreOut` does.
- R5: Activity during sleep drops `sleep` after the next edge. The output register holds for one more cycle after that. It reloads from `coreOut` at the end of the second cycle after the waking transition.
- R6: `pinOe` is all zeros from reset until the clock edge that samples `supplyOk` high. From the edge after that it is all ones and stays all ones until the next reset, even if `supplyOk` falls.
- R7: Synchronous reset (`rst` high) clears the idle count, drives `sleep` low, clears `pinOut` to zero and drives `pinOe` to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| supplyOk | input | 1 | Supply-valid indication |
| monIn | input | MON_W | Monitored vector: inputs, pin inputs, clock select, feedback |
| coreOut | input | OUT_W | Result of the logic core |
| pinOut | output | OUT_W | Registered, freezable copy of the core result |
| pinOe | output | OUT_W | Output enables, all low until supply is valid |
| sleep | output | 1 | Power-down request |

## Verification
The idle count is driven with three input patterns. A vector held steady shows the exact edge on which `sleep` rises and that the count stays saturated. A single toggle part-way through the interval shows that the count restarts rather than pauses. Toggles on the lowest and highest bits show that every monitored lane is watched. The core result is changed while the block is awake, while it is asleep, and on the very cycle of the waking transition. These cases separate the normal one-cycle pipe, the freeze, and the one-cycle wake penalty. The supply input is pulsed high and then dropped to show that the enables turn on one edge late and then stay on.

// File: rtl/pd_pkg.sv
package pd_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic capture; // load the output register this cycle
    logic drive;   // output enables on
  } pdStrobes_t;

endpackage

// File: rtl/pd_datapath.sv
module pd_datapath
  import pd_pkg::*;
#(
  parameter int MON_W = 12,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MON_W-1:0] monIn,
  input  logic [OUT_W-1:0] coreOut,
  input  pdStrobes_t       strobes,
  output logic             activity,
  output logic [OUT_W-1:0] pinOut,
  output logic [OUT_W-1:0] pinOe
);

  logic [MON_W-1:0] monPrev;
  logic [MON_W-1:0] monDiff;

  // previous sample; reset loads the live value so no false activity follows
  always_ff @(posedge clk) begin
    monPrev <= monIn;
  end

  assign monDiff  = monIn ^ monPrev;
  assign activity = |monDiff;

  // one freezable register per output lane
  for (genvar lane = 0; lane < OUT_W; lane++) begin : g_lane
    logic laneQ;
    always_ff @(posedge clk) begin
      if (rst) begin
        laneQ <= 1'b0;
      end else if (strobes.capture) begin
        laneQ <= coreOut[lane];
      end
    end
    assign pinOut[lane] = laneQ;
    assign pinOe[lane]  = strobes.drive;
  end

endmodule

// File: rtl/pd_control.sv
module pd_control
  import pd_pkg::*;
#(
  parameter int IDLE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       activity,
  input  logic       supplyOk,
  output pdStrobes_t strobes,
  output logic       sleep
);

  localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_CYCLES);

  logic [CNT_W-1:0] idleCnt;
  logic             wakePend;
  logic             okSeen;
  logic             asleep;

  assign asleep = (idleCnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      idleCnt  <= '0;
      wakePend <= 1'b0;
      okSeen   <= 1'b0;
    end else begin
      okSeen   <= okSeen | supplyOk;
      wakePend <= activity & asleep;
      if (activity) begin
        idleCnt <= '0;
      end else if (!asleep) begin
        idleCnt <= idleCnt + CNT_W'(1);
      end
    end
  end

  assign strobes.capture = ~asleep & ~wakePend;
  assign strobes.drive   = okSeen;
  assign sleep           = asleep;

endmodule

// File: rtl/idle_pwrdn_ctrl.sv
module idle_pwrdn_ctrl
  import pd_pkg::*;
#(
  parameter int MON_W       = 12,
  parameter int OUT_W       = 8,
  parameter int IDLE_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             supplyOk,
  input  logic [MON_W-1:0] monIn,
  input  logic [OUT_W-1:0] coreOut,
  output logic [OUT_W-1:0] pinOut,
  output logic [OUT_W-1:0] pinOe,
  output logic             sleep
);

  pdStrobes_t strobes;
  logic       activity;

  pd_datapath #(.MON_W(MON_W), .OUT_W(OUT_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .monIn    (monIn),
    .coreOut  (coreOut),
    .strobes  (strobes),
    .activity (activity),
    .pinOut   (pinOut),
    .pinOe    (pinOe)
  );

  pd_control #(.IDLE_CYCLES(IDLE_CYCLES)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .activity (activity),
    .supplyOk (supplyOk),
    .strobes  (strobes),
    .sleep    (sleep)
  );

endmodule

// File: rtl/pd_checker.sv
module pd_checker #(
  parameter int MON_W = 12,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             supplyOk,
  input logic [MON_W-1:0] monIn,
  input logic [OUT_W-1:0] pinOut,
  input logic [OUT_W-1:0] pinOe,
  input logic             sleep
);

  logic pastOk; // one full cycle out of reset
  always_ff @(posedge clk) begin
    if (rst) pastOk <= 1'b0;
    else     pastOk <= 1'b1;
  end

  a_r1_change_wakes: assert property (@(posedge clk) disable iff (rst)
    (pastOk && monIn != $past(monIn)) |=> !sleep);

  a_r4_frozen: assert property (@(posedge clk) disable iff (rst)
    sleep |=> pinOut == $past(pinOut));

  a_r5_wake_penalty: assert property (@(posedge clk) disable iff (rst)
    (pastOk && !sleep && $past(sleep)) |=> $stable(pinOut));

  a_r6_all_or_none: assert property (@(posedge clk) disable iff (rst)
    (pinOe == '0) || (pinOe == '1));

  a_r6_stays_off: assert property (@(posedge clk) disable iff (rst)
    (pinOe == '0 && !supplyOk) |=> pinOe == '0);

  a_r6_stays_on: assert property (@(posedge clk) disable iff (rst)
    (pinOe == '1) |=> pinOe == '1);

endmodule

bind idle_pwrdn_ctrl pd_checker #(.MON_W(MON_W), .OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .supplyOk (supplyOk),
  .monIn    (monIn),
  .pinOut   (pinOut),
  .pinOe    (pinOe),
  .sleep    (sleep)
);

// File: tb/tb_idle_pwrdn_ctrl.sv
module tb_idle_pwrdn_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int MON_W = 12;
  localparam int OUT_W = 8;
  localparam int IDLE  = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             supplyOk = 1'b0;
  logic [MON_W-1:0] monIn = '0;
  logic [OUT_W-1:0] coreOut = '0;
  logic [OUT_W-1:0] pinOut;
  logic [OUT_W-1:0] pinOe;
  logic             sleep;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  idle_pwrdn_ctrl #(.MON_W(MON_W), .OUT_W(OUT_W), .IDLE_CYCLES(IDLE)) dut (
    .clk(clk), .rst(rst), .supplyOk(supplyOk), .monIn(monIn),
    .coreOut(coreOut), .pinOut(pinOut), .pinOe(pinOe), .sleep(sleep)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // advance past n rising edges; inputs change and outputs are read 1 time unit later
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(1);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    supplyOk = 1'b1;
    monIn = 12'h5a5;
    coreOut = 8'hff;
    step(3);
    do_reset();
    check("R7 sleep low after reset", 32'(sleep), 0);
    check("R7 pinOut cleared", 32'(pinOut), 0);
    check("R7 pinOe off", 32'(pinOe), 0);
  endtask

  task automatic t_supply();
    supplyOk = 1'b0;
    do_reset();
    step(6);
    check("R6 enables off without supply", 32'(pinOe), 0);
    supplyOk = 1'b1;
    step(1);
    check("R6 enables on one edge after supply", 32'(pinOe), 32'hff);
    supplyOk = 1'b0;
    step(3);
    check("R6 enables stay on after supply drops", 32'(pinOe), 32'hff);
  endtask

  task automatic t_idle_count();
    do_reset();
    step(IDLE - 1);
    check("R2 not asleep one edge early", 32'(sleep), 0);
    step(1);
    check("R2 asleep after IDLE edges", 32'(sleep), 1);
    step(5);
    check("R2 count saturates, sleep stays", 32'(sleep), 1);
  endtask

  task automatic t_restart();
    do_reset();
    step(IDLE - 1);
    monIn[0] = ~monIn[0]; // low bit activity
    step(1);
    check("R1 low bit toggle keeps awake", 32'(sleep), 0);
    step(IDLE - 1);
    check("R2 count restarted, not yet asleep", 32'(sleep), 0);
    step(1);
    check("R2 asleep IDLE edges after toggle", 32'(sleep), 1);
    monIn[MON_W-1] = ~monIn[MON_W-1]; // feedback lane
    step(1);
    check("R1 high bit toggle wakes", 32'(sleep), 0);
  endtask

  task automatic t_pipe();
    do_reset();
    coreOut = 8'h3c;
    monIn = monIn ^ 12'h010;
    step(1);
    check("R3 one-cycle follow A", 32'(pinOut), 32'h3c);
    coreOut = 8'hc3;
    monIn = monIn ^ 12'h010;
    step(1);
    check("R3 one-cycle follow B", 32'(pinOut), 32'hc3);
  endtask

  task automatic t_freeze_wake();
    do_reset();
    coreOut = 8'h81;
    step(IDLE);
    check("R2 asleep before freeze check", 32'(sleep), 1);
    check("R4 last value latched", 32'(pinOut), 32'h81);
    coreOut = 8'h7e;
    step(4);
    check("R4 held while asleep", 32'(pinOut), 32'h81);
    monIn = monIn ^ 12'h100;
    coreOut = 8'h42;
    step(1);
    check("R5 sleep drops after waking edge", 32'(sleep), 0);
    check("R5 still frozen after first edge", 32'(pinOut), 32'h81);
    step(1);
    check("R5 extra wake cycle still frozen", 32'(pinOut), 32'h81);
    step(1);
    check("R5 reload on second cycle after wake", 32'(pinOut), 32'h42);
  endtask

  task automatic t_reset_while_asleep();
    supplyOk = 1'b1;
    do_reset();
    step(IDLE + 2);
    check("R6 enables on before reset", 32'(pinOe), 32'hff);
    supplyOk = 1'b0;
    do_reset();
    check("R7 reset clears sleep", 32'(sleep), 0);
    check("R7 reset turns enables off", 32'(pinOe), 0);
  endtask

  initial begin
    step(2);
    t_reset_state();
    t_supply();
    t_idle_count();
    t_restart();
    t_pipe();
    t_freeze_wake();
    t_reset_while_asleep();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule